// File: doc/BRIEF.md
# Address-Masked GPIO Port with APB Slave

This block is an eight-pin general-purpose I/O port behind an APB slave. Software sets each pin's direction, its interrupt behaviour and whether it belongs to a hardware function. It reads and writes pin data through a window of data-register aliases. Inside that window, address bits [9:2] act as a per-bit mask. A store can therefore change one pin, or any group of pins, in a single transfer. No read-modify-write is needed, and concurrent agents cannot race on shared bits.

Input pins pass through a two-flop synchronizer. The synchronized value feeds both the data read path and an interrupt engine. For each pin, that engine detects rising edges, falling edges, both edges, or a high or low level. It keeps a raw status vector and masks it with an enable vector. It raises one combined interrupt line. Pin outputs and output enables are registered. For each pin they come either from the software registers or from a hardware function bus.

Top module: `gpio_port_apb`

## Requirements
- R1: After a synchronous reset, every register is 0. All pins are software-controlled inputs: `pin_oe` = 0 and `pin_out` = 0. `irq_out` = 0 and `prdata` = 0.
- R2: A read at any byte address 0x000–0x3FC returns data bit n only if address bit n+2 is 1. All other data bits, and `prdata[31:8]`, read as 0.
- R3: A write at any byte address 0x000–0x3FC loads data bit n from `pwdata[n]` only where address bit n+2 is 1. Every other data bit keeps its value.
- R4: The direction register at 0x400 drives `pin_oe` for software-controlled pins: 1 means output, 0 means input.
- R5: A data read returns the data register bit for output pins. For input pins it returns the input sampled through two flops.
- R6: Where the alternate-select register at 0x420 holds a 1, `pin_out`/`pin_oe` follow `hw_out`/`hw_oe`. The register reads back at 0x420.
- R7: If the sense bit (0x404) is 0, the pin is edge-triggered. A both-edges bit (0x408) of 1 catches either edge. Otherwise a polarity bit (0x40C) of 1 catches rising edges and 0 catches falling edges. A caught edge sets the raw status bit (read at 0x414), and the bit stays set.
- R8: If the sense bit is 1, the raw status bit follows the level: high when polarity is 1, low when polarity is 0. A clear write does not affect it.
- R9: Masked status (read at 0x418) is raw status AND enable (0x410). `irq_out` is the OR of the masked status bits.
- R10: Writing 1 to bit n at 0x41C clears edge raw status bit n. Writing 0 has no effect. If an edge and a clear arrive in the same cycle, the edge wins. The clear register reads as 0.
- R11: `pready` is always 1 and `pslverr` always 0, so every transfer completes with no wait state.
- R12: `pin_out` and `pin_oe` change on the clock edge after the write access edge, not on that edge.
- R13: Addresses that are not mapped read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Registered pin output values |
| pin_oe | output | 8 | Registered pin output enables |
| hw_out | input | 8 | Hardware function output values |
| hw_oe | input | 8 | Hardware function output enables |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
Read data is captured on the setup-phase edge, so it is sampled in the access phase. `pin_out` and `pin_oe` are due one edge after the access edge of a write. A pin change becomes readable two edges after it is applied. It reaches raw status on the third edge and `irq_out` on the fourth. The bench's reference model advances one step per rising edge, with exactly these stage counts. Every output is compared against it at each falling edge. Directed checks wait at least those edge counts before they sample. The R12 checks look one cycle early on purpose, to confirm that the old value is still held.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PIN_COUNT = 8;
  localparam int unsigned APB_AW    = 12;
  localparam int unsigned APB_DW    = 32;

  // byte offsets of the control registers
  localparam int unsigned OFS_DIR   = 'h400;
  localparam int unsigned OFS_SENSE = 'h404;
  localparam int unsigned OFS_BOTH  = 'h408;
  localparam int unsigned OFS_POL   = 'h40C;
  localparam int unsigned OFS_IEN   = 'h410;
  localparam int unsigned OFS_RAW   = 'h414;
  localparam int unsigned OFS_MSK   = 'h418;
  localparam int unsigned OFS_CLR   = 'h41C;
  localparam int unsigned OFS_ALT   = 'h420;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_POL,
    SEL_IEN, SEL_RAW, SEL_MSK, SEL_CLR, SEL_ALT
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_engine.sv
module gpio_irq_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_in,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] raw_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] level_hit;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_det
    logic rise, fall;
    assign rise         = level_in[i] & ~prev_q[i];
    assign fall         = ~level_in[i] & prev_q[i];
    assign edge_hit[i]  = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign level_hit[i] = pol[i] ? level_in[i] : ~level_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      raw_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= level_in;
      raw_q  <= (sense & level_hit) | (~sense & ((raw_q & ~clr) | edge_hit));
      irq_q  <= |(raw_q & ien);
    end
  end

  assign raw_o = raw_q;
  assign irq_o = irq_q;

  // edge-mode status only drops through a clear write
  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(raw_q) & ~raw_q & ~$past(sense) & ~$past(clr)) == '0));

  // the interrupt line needs an enabled pending bit one cycle earlier
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(raw_q & ien)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq_q);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] alt_sel,
  input  logic [W-1:0] sw_out,
  input  logic [W-1:0] sw_oe,
  input  logic [W-1:0] hw_out,
  input  logic [W-1:0] hw_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic o_q, e_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        o_q <= 1'b0;
        e_q <= 1'b0;
      end else if (alt_sel[p]) begin
        o_q <= hw_out[p];
        e_q <= hw_oe[p];
      end else begin
        o_q <= sw_out[p];
        e_q <= sw_oe[p];
      end
    end
    assign pin_out[p] = o_q;
    assign pin_oe[p]  = e_q;
  end

  // a software input pin is never driven
  assert_input_undriven_R4: assert property (@(posedge clk) disable iff (rst)
    ((~$past(sw_oe) & ~$past(alt_sel) & pin_oe) == '0));
endmodule

// File: rtl/gpio_port_apb.sv
module gpio_port_apb
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = PIN_COUNT,
  parameter int unsigned AW          = APB_AW,
  parameter int unsigned DW          = APB_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NPINS-1:0] hw_out,
  input  logic [NPINS-1:0] hw_oe,
  output logic             irq_out
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = MASK_LO + NPINS - 1;
  localparam int unsigned WIN_SH  = NPINS + 2;
  localparam logic [AW-1:0] A_DIR   = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_SENSE = AW'(OFS_SENSE);
  localparam logic [AW-1:0] A_BOTH  = AW'(OFS_BOTH);
  localparam logic [AW-1:0] A_POL   = AW'(OFS_POL);
  localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN);
  localparam logic [AW-1:0] A_RAW   = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MSK   = AW'(OFS_MSK);
  localparam logic [AW-1:0] A_CLR   = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_ALT   = AW'(OFS_ALT);

  reg_sel_e         sel;
  logic             wr_en, rd_setup;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, ien_q, alt_q;
  logic [NPINS-1:0] clr_pulse, pin_sync, raw_st, rd_val;
  logic [DW-1:0]    prdata_q;
  logic             unused_bits;

  assign wr_en    = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign mask     = paddr[MASK_HI:MASK_LO];
  assign unused_bits = ^{paddr[1:0], pwdata[DW-1:NPINS]};

  always_comb begin
    sel = SEL_NONE;
    if ((paddr >> WIN_SH) == '0) begin
      sel = SEL_DATA;
    end else begin
      case ({paddr[AW-1:2], 2'b00})
        A_DIR:   sel = SEL_DIR;
        A_SENSE: sel = SEL_SENSE;
        A_BOTH:  sel = SEL_BOTH;
        A_POL:   sel = SEL_POL;
        A_IEN:   sel = SEL_IEN;
        A_RAW:   sel = SEL_RAW;
        A_MSK:   sel = SEL_MSK;
        A_CLR:   sel = SEL_CLR;
        A_ALT:   sel = SEL_ALT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      alt_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:  data_q  <= (data_q & ~mask) | (pwdata[NPINS-1:0] & mask);
        SEL_DIR:   dir_q   <= pwdata[NPINS-1:0];
        SEL_SENSE: sense_q <= pwdata[NPINS-1:0];
        SEL_BOTH:  both_q  <= pwdata[NPINS-1:0];
        SEL_POL:   pol_q   <= pwdata[NPINS-1:0];
        SEL_IEN:   ien_q   <= pwdata[NPINS-1:0];
        SEL_ALT:   alt_q   <= pwdata[NPINS-1:0];
        default:   ;
      endcase
    end
  end

  assign clr_pulse = (wr_en && sel == SEL_CLR) ? pwdata[NPINS-1:0] : '0;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  gpio_irq_engine #(.W(NPINS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .level_in (pin_sync),
    .sense    (sense_q),
    .both     (both_q),
    .pol      (pol_q),
    .ien      (ien_q),
    .clr      (clr_pulse),
    .raw_o    (raw_st),
    .irq_o    (irq_out)
  );

  gpio_pin_mux #(.W(NPINS)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .alt_sel (alt_q),
    .sw_out  (data_q),
    .sw_oe   (dir_q),
    .hw_out  (hw_out),
    .hw_oe   (hw_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    case (sel)
      SEL_DATA:  rd_val = ((dir_q & data_q) | (~dir_q & pin_sync)) & mask;
      SEL_DIR:   rd_val = dir_q;
      SEL_SENSE: rd_val = sense_q;
      SEL_BOTH:  rd_val = both_q;
      SEL_POL:   rd_val = pol_q;
      SEL_IEN:   rd_val = ien_q;
      SEL_RAW:   rd_val = raw_st;
      SEL_MSK:   rd_val = raw_st & ien_q;
      SEL_ALT:   rd_val = alt_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata_q <= '0;
    else if (rd_setup) prdata_q <= {{(DW-NPINS){1'b0}}, rd_val};
  end

  assign prdata  = prdata_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DATA) |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));

  assert_masked_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && sel == SEL_DATA) |=> ((prdata_q & ~{{(DW-NPINS){1'b0}}, $past(mask)}) == '0));
endmodule

// File: tb/sim_gpio_port_apb.sv
module sim_gpio_port_apb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_out;
  logic [7:0]  pin_in = '0, hw_out = '0, hw_oe = '0;
  logic [7:0]  pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  gpio_port_apb u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .hw_out(hw_out), .hw_oe(hw_oe), .irq_out(irq_out)
  );

  // behavioural reference model, one step per rising edge
  logic [7:0]  m_data, m_dir, m_sense, m_both, m_pol, m_ien, m_alt, m_raw;
  logic [7:0]  m_s1, m_s2, m_prev, m_out, m_oe;
  logic        m_irq;
  logic [31:0] m_prdata;

  function automatic logic [7:0] model_read(input logic [11:0] a);
    logic [7:0] mk;
    mk = a[9:2];
    if (a[11:10] == 2'b00) return ((m_dir & m_data) | (~m_dir & m_s2)) & mk;
    case ({a[11:2], 2'b00})
      12'h400: return m_dir;
      12'h404: return m_sense;
      12'h408: return m_both;
      12'h40C: return m_pol;
      12'h410: return m_ien;
      12'h414: return m_raw;
      12'h418: return m_raw & m_ien;
      12'h420: return m_alt;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] rise, fall, ehit, lhit, clr, n_raw, n_out, n_oe;
    logic       n_irq;
    logic [11:0] w;
    if (rst) begin
      {m_data, m_dir, m_sense, m_both, m_pol, m_ien, m_alt, m_raw} = '0;
      {m_s1, m_s2, m_prev, m_out, m_oe} = '0;
      m_irq = 1'b0;
      m_prdata = '0;
    end else begin
      w = {paddr[11:2], 2'b00};
      n_out = (m_alt & hw_out) | (~m_alt & m_data);
      n_oe  = (m_alt & hw_oe) | (~m_alt & m_dir);
      n_irq = |(m_raw & m_ien);
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      for (int i = 0; i < 8; i++)
        ehit[i] = m_both[i] ? (rise[i] | fall[i]) : (m_pol[i] ? rise[i] : fall[i]);
      lhit = (m_pol & m_s2) | (~m_pol & ~m_s2);
      clr = (psel && penable && pwrite && paddr[11:10] != 2'b00 && w == 12'h41C) ? pwdata[7:0] : 8'h00;
      n_raw = (m_sense & lhit) | (~m_sense & ((m_raw & ~clr) | ehit));
      if (psel && !penable && !pwrite) m_prdata = {24'h0, model_read(paddr)};
      if (psel && penable && pwrite) begin
        if (paddr[11:10] == 2'b00)
          m_data = (m_data & ~paddr[9:2]) | (pwdata[7:0] & paddr[9:2]);
        else case (w)
          12'h400: m_dir   = pwdata[7:0];
          12'h404: m_sense = pwdata[7:0];
          12'h408: m_both  = pwdata[7:0];
          12'h40C: m_pol   = pwdata[7:0];
          12'h410: m_ien   = pwdata[7:0];
          12'h420: m_alt   = pwdata[7:0];
          default: ;
        endcase
      end
      m_raw = n_raw; m_out = n_out; m_oe = n_oe; m_irq = n_irq;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R3 pin_out vs model", {24'h0, pin_out}, {24'h0, m_out});
      chk("R4 pin_oe vs model", {24'h0, pin_oe}, {24'h0, m_oe});
      chk("R9 irq_out vs model", {31'h0, irq_out}, {31'h0, m_irq});
      chk("R2 prdata vs model", prdata, m_prdata);
      chk("R11 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    cmp_en = 1'b1;
    wait_n(1);
    chk("R1 reset pin_oe", {24'h0, pin_oe}, 32'h0);
    chk("R1 reset pin_out", {24'h0, pin_out}, 32'h0);
    chk("R1 reset irq", {31'h0, irq_out}, 32'h0);
    chk("R1 reset prdata", prdata, 32'h0);
    rd_chk("R1 direction reset", 12'h400, 32'h0);
    rd_chk("R1 alt reset", 12'h420, 32'h0);

    apb_wr(12'h400, 32'hFF);
    chk("R12 pin_oe held one cycle", {24'h0, pin_oe}, 32'h00);
    wait_n(1);
    chk("R4 all outputs", {24'h0, pin_oe}, 32'hFF);

    apb_wr(12'h3FC, 32'hA5);
    wait_n(1);
    chk("R3 full-mask write", {24'h0, pin_out}, 32'hA5);
    apb_wr(12'h00C, 32'h5A);
    wait_n(1);
    chk("R3 pins 0-1 only", {24'h0, pin_out}, 32'hA6);
    rd_chk("R2 mask pins 2-5", 12'h0F0, 32'h24);
    rd_chk("R2 empty mask", 12'h000, 32'h0);

    apb_wr(12'h400, 32'h0F);
    chk("R12 pin_oe held one cycle", {24'h0, pin_oe}, 32'hFF);
    wait_n(1);
    chk("R4 upper nibble inputs", {24'h0, pin_oe}, 32'h0F);

    pin_in = 8'hC0;
    wait_n(3);
    rd_chk("R5 mixed read-back", 12'h3FC, 32'hC6);
    rd_chk("R2 pin 7 only", 12'h200, 32'h80);
    rd_chk("R5 output pin0 from register", 12'h004, 32'h00);

    hw_out = 8'h01; hw_oe = 8'h00;
    apb_wr(12'h420, 32'h01);
    wait_n(1);
    chk("R6 hw drives pin0 value", {24'h0, pin_out}, 32'hA7);
    chk("R6 hw drives pin0 enable", {24'h0, pin_oe}, 32'h0E);
    rd_chk("R6 alt read-back", 12'h420, 32'h01);
    apb_wr(12'h420, 32'h00);

    apb_wr(12'h800, 32'hFF);
    wait_n(1);
    rd_chk("R13 unmapped write ignored", 12'h400, 32'h0F);
    rd_chk("R13 unmapped read", 12'h800, 32'h0);
    rd_chk("R10 clear reads zero", 12'h41C, 32'h0);
    chk("R13 pin_out unchanged", {24'h0, pin_out}, 32'hA6);

    pin_in = 8'h00;
    wait_n(5);
    apb_wr(12'h41C, 32'hFF);
    rd_chk("R10 clear all", 12'h414, 32'h0);

    apb_wr(12'h40C, 32'h10);
    apb_wr(12'h410, 32'h10);
    pin_in = 8'h10;
    wait_n(5);
    chk("R7 rising edge irq", {31'h0, irq_out}, 32'h1);
    rd_chk("R7 raw rising", 12'h414, 32'h10);
    rd_chk("R9 masked status", 12'h418, 32'h10);
    apb_wr(12'h41C, 32'h00);
    rd_chk("R10 zero clear no effect", 12'h414, 32'h10);
    apb_wr(12'h41C, 32'h10);
    wait_n(2);
    chk("R10 irq dropped", {31'h0, irq_out}, 32'h0);
    rd_chk("R10 raw cleared", 12'h414, 32'h0);

    pin_in = 8'h00;
    wait_n(5);
    rd_chk("R7 falling ignored", 12'h414, 32'h0);

    apb_wr(12'h408, 32'h10);
    pin_in = 8'h10;
    wait_n(5);
    rd_chk("R7 both-edges rise", 12'h414, 32'h10);
    apb_wr(12'h41C, 32'h10);
    pin_in = 8'h00;
    wait_n(5);
    rd_chk("R7 both-edges fall", 12'h414, 32'h10);

    apb_wr(12'h410, 32'h00);
    wait_n(2);
    chk("R9 disabled no irq", {31'h0, irq_out}, 32'h0);
    rd_chk("R9 masked zero", 12'h418, 32'h0);
    apb_wr(12'h41C, 32'h10);

    apb_wr(12'h404, 32'h20);
    apb_wr(12'h40C, 32'h30);
    apb_wr(12'h410, 32'h20);
    pin_in = 8'h20;
    wait_n(5);
    chk("R8 high level irq", {31'h0, irq_out}, 32'h1);
    apb_wr(12'h41C, 32'h20);
    rd_chk("R8 level not clearable", 12'h414, 32'h20);
    pin_in = 8'h00;
    wait_n(5);
    rd_chk("R8 level gone", 12'h414, 32'h0);
    chk("R8 irq follows level", {31'h0, irq_out}, 32'h0);
    apb_wr(12'h40C, 32'h10);
    wait_n(3);
    rd_chk("R8 low level", 12'h414, 32'h20);
    chk("R11 pready", {31'h0, pready}, 32'h1);
    chk("R11 pslverr", {31'h0, pslverr}, 32'h0);

    wait_n(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule